// File: doc/BRIEF.md
# Phase-Shifted Carrier PWM Generator

This block drives the switches of a stack of series-connected boost cells. Every cell owns a triangular carrier that counts from zero up to a programmable period value and back down again. The carriers of the cells run at the same rate but start at evenly spaced positions around the carrier cycle. One shared duty reference is compared against each carrier, so each cell receives its own registered gate bit.

Because the carriers are staggered, the cells switch at different instants. The summed output of the stack therefore switches at the per-cell carrier rate multiplied by the number of cells. The default has three cells. At 10 kHz per carrier the stack switches at an equivalent 30 kHz. All cells share one reference, so they carry equal parts of the stack voltage.

The reference is taken into the block only at the top of cell 0's carrier, so no pulse is ever cut short mid-period. The period value is taken only while the block is disabled. A one-cycle strobe marks each peak of cell 0's carrier, so a control loop can align its updates with it.

Top module: `phase_shift_pwm`

## Requirements
- R1: While `rst` is high, or while `en` was low at the previous clock edge, every bit of `gate_o` and `peak_o` is 0. Re-enabling restarts every carrier from its preload position.
- R2: With the active period P ≥ 1, each carrier walks 0,1,…,P,P−1,…,1 and repeats every 2P cycles. `peak_o` is high for exactly one cycle, directly after the edge at which cell 0's count equals P, and so recurs every 2P cycles.
- R3: On each enable, cell k (k = 0…NUM_CELLS−1) starts at carrier position floor(2·P·k/NUM_CELLS), where positions 0…P count upward and positions P+1…2P−1 count downward. As a result, gate k repeats the sequence of gate 0 shifted earlier by that many cycles.
- R4: After each enabled clock edge, `gate_o[k]` is 1 when the held reference is strictly greater than cell k's count before that edge, or when the held reference is ≥ P.
- R5: A held reference of 0 keeps every gate low.
- R6: A held reference ≥ P keeps every gate high.
- R7: While enabled, `duty_i` is taken into the held reference only at an edge where cell 0's count equals P. While disabled, the held reference follows `duty_i`.
- R8: `period_i` is taken as the active period only at edges where `en` is low or `rst` is high. Changes while enabled have no effect on the carriers.
- R9: For a held reference r with 0 < r < P, each gate is high for 2r−1 cycles in every 2P-cycle window.
- R10: In every 2P-cycle window the gate bits together show exactly NUM_CELLS rising edges, one for each cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds carriers at their preload positions |
| period_i | input | CNT_W | Carrier peak count P, taken while disabled |
| duty_i | input | CNT_W | Shared duty reference |
| gate_o | output | NUM_CELLS | Registered gate bit for each cell |
| peak_o | output | 1 | One-cycle strobe after cell 0's carrier peak |

## Verification
The bench goes after the phase stagger with a period that 2P·k/NUM_CELLS does not divide evenly, where a design that rounds up or swaps the count direction shows gates shifted by one cycle. It changes the reference in the middle of a carrier period: a design that takes the new value at once produces a shortened pulse before the next peak. It drives references of 0, of exactly P and above P. A strict compare without saturation leaves a one-cycle notch at the peak when the reference equals P. It also changes the period while running and toggles the enable mid-cycle, where a leaky design would warp the peak spacing or resume from a stale carrier position.

// File: rtl/pspwm_pkg.sv
package pspwm_pkg;

  // Carrier position at which a cell starts, out of a 2*per cycle.
  function automatic longint unsigned lead_steps(longint unsigned per,
                                                 longint unsigned idx,
                                                 longint unsigned cells);
    return (2 * per * idx) / cells;
  endfunction

endpackage

// File: rtl/pspwm_carrier.sv
module pspwm_carrier
  import pspwm_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NUM_CELLS = 3,
  parameter int CELL_IDX  = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] per_i,     // live period, used for the preload
  input  logic [CNT_W-1:0] per_q_i,   // active period
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_peak_o
);
  localparam int PW = CNT_W + 1;

  logic [PW-1:0] span, preload, pos_q, pos_inc, top;

  assign span    = {per_q_i, 1'b0};
  assign top     = {1'b0, per_q_i};
  assign preload = PW'(lead_steps(longint'(per_i), longint'(CELL_IDX),
                                  longint'(NUM_CELLS)));
  assign pos_inc = pos_q + 1'b1;

  // Phase position around the 2P cycle; rising half then falling half.
  always_ff @(posedge clk) begin
    if (rst || !en)          pos_q <= preload;
    else if (pos_inc >= span) pos_q <= '0;
    else                     pos_q <= pos_inc;
  end

  assign cnt_o     = (pos_q <= top) ? pos_q[CNT_W-1:0] : CNT_W'(span - pos_q);
  assign at_peak_o = (pos_q == top);

  // R2
  tri_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && per_q_i != '0) |=>
      (cnt_o == $past(cnt_o) + 1'b1 || cnt_o == $past(cnt_o) - 1'b1));

  // R3
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    (span != '0) |-> (pos_q < span));

endmodule

// File: rtl/pspwm_ref_hold.sv
module pspwm_ref_hold #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic [CNT_W-1:0] ref_o
);
  always_ff @(posedge clk) begin
    if (rst || !en)  ref_o <= duty_i;
    else if (load_i) ref_o <= duty_i;
  end

  // R7
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !load_i) |=> (ref_o == $past(ref_o)));

endmodule

// File: rtl/pspwm_gate_bank.sv
module pspwm_gate_bank #(
  parameter int CNT_W     = 16,
  parameter int NUM_CELLS = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic [CNT_W-1:0]           ref_i,
  input  logic [CNT_W-1:0]           per_i,
  input  logic [NUM_CELLS*CNT_W-1:0] cnt_flat_i,
  output logic [NUM_CELLS-1:0]       gate_o
);
  logic sat;
  assign sat = (ref_i >= per_i);

  for (genvar k = 0; k < NUM_CELLS; k++) begin : g_cell
    logic [CNT_W-1:0] c;
    logic             hit;
    assign c   = cnt_flat_i[k*CNT_W +: CNT_W];
    assign hit = sat || (ref_i > c);
    always_ff @(posedge clk) begin
      if (rst || !en) gate_o[k] <= 1'b0;
      else            gate_o[k] <= hit;
    end
  end

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (gate_o == '0));

  // R5
  zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (en && ref_i == '0 && per_i != '0) |=> (gate_o == '0));

  // R6
  full_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (en && ref_i >= per_i) |=> (&gate_o));

endmodule

// File: rtl/phase_shift_pwm.sv
module phase_shift_pwm #(
  parameter int CNT_W     = 16,
  parameter int NUM_CELLS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [CNT_W-1:0]     period_i,
  input  logic [CNT_W-1:0]     duty_i,
  output logic [NUM_CELLS-1:0] gate_o,
  output logic                 peak_o
);
  logic [CNT_W-1:0]           per_q, ref_q;
  logic [NUM_CELLS*CNT_W-1:0] cnt_flat;
  logic [NUM_CELLS-1:0]       at_peak;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      per_q  <= period_i;
      peak_o <= 1'b0;
    end else begin
      peak_o <= at_peak[0];
    end
  end

  for (genvar k = 0; k < NUM_CELLS; k++) begin : g_car
    pspwm_carrier #(
      .CNT_W(CNT_W), .NUM_CELLS(NUM_CELLS), .CELL_IDX(k)
    ) u_car (
      .clk(clk), .rst(rst), .en(en),
      .per_i(period_i), .per_q_i(per_q),
      .cnt_o(cnt_flat[k*CNT_W +: CNT_W]),
      .at_peak_o(at_peak[k])
    );
  end

  pspwm_ref_hold #(.CNT_W(CNT_W)) u_ref (
    .clk(clk), .rst(rst), .en(en), .load_i(at_peak[0]),
    .duty_i(duty_i), .ref_o(ref_q)
  );

  pspwm_gate_bank #(.CNT_W(CNT_W), .NUM_CELLS(NUM_CELLS)) u_gates (
    .clk(clk), .rst(rst), .en(en), .ref_i(ref_q), .per_i(per_q),
    .cnt_flat_i(cnt_flat), .gate_o(gate_o)
  );

  // R8
  per_hold_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (per_q == $past(per_q)));

  // R2
  peak_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (peak_o && per_q != '0 && en) |=> !peak_o);

endmodule

// File: tb/phase_shift_pwm_test.sv
module phase_shift_pwm_test;
  localparam int W = 16;
  localparam int M = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic [W-1:0] per_in = 16'd9;
  logic [W-1:0] duty_in = 16'd4;
  logic [M-1:0] gate_o;
  logic         peak_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int       m_pos [M];
  int       m_per, m_ref;
  logic [M-1:0] e_gate;
  logic     e_peak;
  int       cyc = 0;

  always #2 clk = ~clk;

  phase_shift_pwm #(.CNT_W(W), .NUM_CELLS(M)) uut (
    .clk(clk), .rst(rst), .en(en), .period_i(per_in), .duty_i(duty_in),
    .gate_o(gate_o), .peak_o(peak_o)
  );

  function automatic int tri_of(int pos, int per);
    return (pos <= per) ? pos : 2 * per - pos;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic model_advance();
    if (rst || !en) begin
      for (int k = 0; k < M; k++) m_pos[k] = (2 * int'(per_in) * k) / M;
      m_per = int'(per_in);
      m_ref = int'(duty_in);
      e_gate = '0;
      e_peak = 1'b0;
    end else begin
      for (int k = 0; k < M; k++)
        e_gate[k] = (m_ref >= m_per) || (m_ref > tri_of(m_pos[k], m_per));
      e_peak = (m_pos[0] == m_per);
      if (e_peak) m_ref = int'(duty_in);
      for (int k = 0; k < M; k++)
        m_pos[k] = (m_pos[k] + 1 >= 2 * m_per) ? 0 : m_pos[k] + 1;
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_advance();
    @(negedge clk);
    cyc++;
    check({tag, " gate"}, int'(gate_o), int'(e_gate));
    check({tag, " peak"}, int'(peak_o), int'(e_peak));
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b0;
    for (int i = 0; i < 3; i++) step("R1 reset");
    rst = 1'b0;
    step("R1 idle");
  endtask

  task automatic t_basic();
    int g0 [40];
    int g1 [40];
    int highs = 0, rises = 0, last_pk = -1;
    logic [M-1:0] prev;
    en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      step("R4");
      g0[i] = int'(gate_o[0]);
      g1[i] = int'(gate_o[1]);
      if (peak_o) begin
        if (last_pk >= 0) check("R2 peak spacing", i - last_pk, 18);
        last_pk = i;
      end
    end
    begin
      int bad = 0;
      for (int t = 0; t + 6 < 40; t++) if (g1[t] != g0[t + 6]) bad++;
      check("R3 cell1 leads cell0 by 6", bad, 0);
    end
    prev = gate_o;
    for (int i = 0; i < 18; i++) begin
      step("R4");
      if (gate_o[0]) highs++;
      for (int k = 0; k < M; k++) if (gate_o[k] && !prev[k]) rises++;
      prev = gate_o;
    end
    check("R9 high cycles r=4 P=9", highs, 7);
    check("R10 rising edges per period", rises, 3);
  endtask

  task automatic t_latch();
    duty_in = 16'd7;
    for (int i = 0; i < 30; i++) step("R7");
    duty_in = 16'd2;
    for (int i = 0; i < 30; i++) step("R7");
  endtask

  task automatic t_levels(int r, string tag);
    int bad = 0;
    duty_in = W'(r);
    for (int i = 0; i < 40; i++) step(tag);
    for (int i = 0; i < 18; i++) begin
      step(tag);
      if (r == 0 && gate_o != '0) bad++;
      if (r != 0 && gate_o != '1) bad++;
    end
    check({tag, " level held"}, bad, 0);
  endtask

  task automatic t_disable();
    duty_in = 16'd5;
    for (int i = 0; i < 25; i++) step("R4");
    en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step("R1 disabled");
      check("R1 gates low", int'(gate_o), 0);
    end
    en = 1'b1;
    for (int i = 0; i < 30; i++) step("R1 restart");
  endtask

  task automatic t_period();
    int last_pk = -1;
    per_in = 16'd10;
    for (int i = 0; i < 40; i++) begin
      step("R8");
      if (peak_o) begin
        if (last_pk >= 0) check("R8 spacing kept", i - last_pk, 18);
        last_pk = i;
      end
    end
    en = 1'b0;
    step("R8 reload");
    en = 1'b1;
    last_pk = -1;
    for (int i = 0; i < 60; i++) begin
      step("R3 P=10");
      if (peak_o) begin
        if (last_pk >= 0) check("R2 spacing P=10", i - last_pk, 20);
        last_pk = i;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_basic();
    t_latch();
    t_levels(0, "R5");
    t_levels(9, "R6");
    t_levels(200, "R6");
    t_disable();
    t_period();
    finish_run();
  end

endmodule